// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital core of a 128-position adjustable resistor. A host drives three slow control lines: an active-low select, an active-low step strobe and a direction line. The block turns them into a 7-bit wiper position. While selected, each falling edge of the step strobe moves the position one place up or down, and the position stops at either end instead of wrapping.

The block also keeps a single non-volatile word. When the host deselects the block, the level of the step strobe at that moment decides whether the current position is saved. A high level starts a save; a low level discards it. The save runs through a busy window whose length is a parameter counted in clock cycles. After each power-on reset the block holds itself busy for a short recall window and then copies the saved word into the position. The three control lines pass through synchronisers clocked by the system clock, and the clock must be fast enough to resolve the shortest strobe phase.

Top module: `updown_wiper_ctrl`

## Requirements
- R1: After reset is released, `busy` is high for the recall window and `tap_pos` then equals bits [6:0] of the saved word, with `busy` low.
- R2: With `sel_n` low and `dir_up` = 1, each high-to-low transition of `step_n` raises `tap_pos` by exactly one.
- R3: With `sel_n` low and `dir_up` = 0, each high-to-low transition of `step_n` lowers `tap_pos` by exactly one.
- R4: At position 127, further up steps leave `tap_pos` at 127.
- R5: At position 0, further down steps leave `tap_pos` at 0.
- R6: While `sel_n` is high, activity on `step_n` and `dir_up` leaves `tap_pos` unchanged.
- R7: A low-to-high transition of `sel_n` while `step_n` is high saves the position. `busy` goes high for the write window. At the end of that window `nv_word` equals the position, zero-extended to 8 bits with the position in bits [6:0].
- R8: A low-to-high transition of `sel_n` while `step_n` is low saves nothing. `nv_word` keeps its value and `busy` stays low.
- R9: While `busy` is high, step edges and further save requests have no effect. `tap_pos` is unchanged and the value that was being written is the one kept.
- R10: A save does not alter `tap_pos`. A later reset recalls the saved position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; acts as power-on |
| sel_n | input | 1 | Active-low select, asynchronous to clk |
| step_n | input | 1 | Active-low step strobe, asynchronous to clk |
| dir_up | input | 1 | Step direction: 1 up, 0 down |
| tap_pos | output | 7 | Current wiper position |
| nv_word | output | 8 | Saved non-volatile word |
| busy | output | 1 | High during recall and during a non-volatile write |

## Verification
The hardest case to reach is host activity inside the write window. The host must first deselect with the strobe high to start a save. It must then select the block again, pulse the strobe and request a second save, all before the window closes. The bench shortens the write window to a few hundred cycles so that this traffic fits inside it. It then checks that the position is frozen and that the first value is the one kept. A reset after that save proves the round trip through the recall path.

// File: rtl/wiper_pkg.sv
// Package: shared types for the up/down wiper controller.
// Assumes: nothing beyond IEEE 1800-2017.
package wiper_pkg;
    typedef enum logic [1:0] {
        CTL_RECALL = 2'd0,
        CTL_IDLE   = 2'd1,
        CTL_WRITE  = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/wiper_sync.sv
// Module: multi-bit, multi-stage synchroniser for asynchronous control lines.
// Assumes: every bit is an independent slow level; reset value is the idle level.
module wiper_sync #(
    parameter int unsigned         WIDTH   = 3,
    parameter int unsigned         STAGES  = 2,
    parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first stage captures the raw asynchronous inputs
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= async_in;
            end
        end else begin : g_next
            // later stages resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/wiper_tap.sv
// Module: saturating tap position register with a parallel load.
// Assumes: load and step never both matter at once (load wins).
module wiper_tap #(
    parameter int unsigned TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [TAP_W-1:0] load_val,
    input  logic             step_en,
    input  logic             step_up,
    output logic [TAP_W-1:0] tap_q
);
    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};
    localparam logic [TAP_W-1:0] TAP_MIN = '0;

    logic [TAP_W-1:0] tap_r;
    logic             at_top;
    logic             at_bot;

    // end-stop detection
    always_comb begin
        at_top = (tap_r == TAP_MAX);
        at_bot = (tap_r == TAP_MIN);
    end

    // position update: load, or one saturating step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_r <= TAP_MIN;
        end else if (load_en) begin
            tap_r <= load_val;
        end else if (step_en) begin
            if (step_up && !at_top)      tap_r <= tap_r + 1'b1;
            else if (!step_up && !at_bot) tap_r <= tap_r - 1'b1;
        end
    end

    assign tap_q = tap_r;
endmodule

// File: rtl/wiper_nvcell.sv
// Module: behavioural non-volatile word behind a write-busy timer.
// Assumes: the stored word survives rst_n (models retention); it starts
// from NV_INIT at time zero. A write request while busy is dropped.
module wiper_nvcell #(
    parameter int unsigned        NV_W         = 8,
    parameter int unsigned        WRITE_CYCLES = 1500000,
    parameter logic [NV_W-1:0]    NV_INIT      = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [NV_W-1:0] wr_data,
    output logic [NV_W-1:0] word_q,
    output logic            busy
);
    localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [NV_W-1:0]  cell_r = NV_INIT;
    logic [NV_W-1:0]  pend_r;
    logic [CNT_W-1:0] cnt_r;

    // write window timer and pending data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_r  <= '0;
            pend_r <= '0;
        end else if (wr_en && cnt_r == '0) begin
            cnt_r  <= CNT_LOAD;
            pend_r <= wr_data;
        end else if (cnt_r != '0) begin
            cnt_r  <= cnt_r - 1'b1;
        end
    end

    // commit at the last cycle of the window; no reset (retained content)
    always_ff @(posedge clk) begin
        if (rst_n && cnt_r == CNT_ONE) cell_r <= pend_r;
    end

    assign word_q = cell_r;
    assign busy   = (cnt_r != '0);
endmodule

// File: rtl/updown_wiper_ctrl.sv
// Module: top of the up/down wiper controller. Synchronises the three
// host lines, detects edges, steps the tap, saves it on deselect and
// recalls the saved word after reset.
// Assumes: host strobe phases span several clock cycles; rst_n is power-on.
module updown_wiper_ctrl #(
    parameter int unsigned     TAP_W         = 7,
    parameter int unsigned     NV_W          = 8,
    parameter int unsigned     SYNC_STAGES   = 2,
    parameter int unsigned     WRITE_CYCLES  = 1500000,
    parameter int unsigned     RECALL_CYCLES = 4,
    parameter logic [NV_W-1:0] NV_INIT       = 8'h40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             step_n,
    input  logic             dir_up,
    output logic [TAP_W-1:0] tap_pos,
    output logic [NV_W-1:0]  nv_word,
    output logic             busy
);
    import wiper_pkg::*;

    localparam int unsigned LINE_N = 3;
    localparam int unsigned RC_W   = $clog2(RECALL_CYCLES + 1);
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(RECALL_CYCLES - 1);
    // idle levels: deselected, strobe high, direction down
    localparam logic [LINE_N-1:0] LINE_IDLE = 3'b110;

    logic [LINE_N-1:0] line_s;
    logic              sel_s, step_s, dir_s;
    logic              sel_d, step_d;
    logic              step_fall, sel_rise;
    ctl_state_e        state_q;
    logic [RC_W-1:0]   rc_q;
    logic              load_en, step_en, wr_en;
    logic              nv_busy;
    logic [TAP_W-1:0]  tap_q;
    logic [NV_W-1:0]   word_q;

    wiper_sync #(
        .WIDTH  (LINE_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(LINE_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({sel_n, step_n, dir_up}),
        .sync_out(line_s)
    );

    assign {sel_s, step_s, dir_s} = line_s;

    // one-cycle delayed copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_d  <= 1'b1;
            step_d <= 1'b1;
        end else begin
            sel_d  <= sel_s;
            step_d <= step_s;
        end
    end

    // edge decode on synchronised lines
    always_comb begin
        step_fall = step_d && !step_s;
        sel_rise  = !sel_d && sel_s;
    end

    // command decode: only the idle state accepts host commands
    always_comb begin
        load_en = (state_q == CTL_RECALL) && (rc_q == RC_LAST);
        step_en = (state_q == CTL_IDLE) && step_fall && !sel_s;
        wr_en   = (state_q == CTL_IDLE) && sel_rise && step_s;
    end

    // control sequencer: recall after reset, idle, write window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTL_RECALL;
            rc_q    <= '0;
        end else begin
            unique case (state_q)
                CTL_RECALL: begin
                    rc_q <= rc_q + 1'b1;
                    if (rc_q == RC_LAST) state_q <= CTL_IDLE;
                end
                CTL_IDLE: begin
                    if (wr_en) state_q <= CTL_WRITE;
                end
                CTL_WRITE: begin
                    if (!nv_busy) state_q <= CTL_IDLE;
                end
                default: state_q <= CTL_IDLE;
            endcase
        end
    end

    wiper_tap #(
        .TAP_W(TAP_W)
    ) u_tap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .load_val(word_q[TAP_W-1:0]),
        .step_en (step_en),
        .step_up (dir_s),
        .tap_q   (tap_q)
    );

    wiper_nvcell #(
        .NV_W        (NV_W),
        .WRITE_CYCLES(WRITE_CYCLES),
        .NV_INIT     (NV_INIT)
    ) u_nv (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(NV_W'(tap_q)),
        .word_q (word_q),
        .busy   (nv_busy)
    );

    assign tap_pos = tap_q;
    assign nv_word = word_q;
    assign busy    = (state_q != CTL_IDLE);
endmodule

// File: rtl/wiper_ctrl_chk.sv
// Module: assertion checker for updown_wiper_ctrl, attached by bind.
// Assumes: observes only the top-level ports.
module wiper_ctrl_chk #(
    parameter int unsigned TAP_W = 7,
    parameter int unsigned NV_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TAP_W-1:0] tap_pos,
    input logic [NV_W-1:0]  nv_word,
    input logic             busy
);
    // R1: first cycle out of reset is always busy (recall window)
    p_busy_recall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> busy);

    // R2 / R3 / R4 / R5: in idle the position moves by at most one, never wraps
    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |->
            (({1'b0, tap_pos} == {1'b0, $past(tap_pos)}) ||
             ({1'b0, tap_pos} == {1'b0, $past(tap_pos)} + 1'b1) ||
             ({1'b0, tap_pos} + 1'b1 == {1'b0, $past(tap_pos)})));

    // R9: position is frozen throughout a busy window
    p_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tap_pos));

    // R8: the saved word never changes outside a busy window
    p_nv_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(nv_word));

    // R7 / R10: any change of the saved word carries the current position
    p_write_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_word != $past(nv_word)) |-> (nv_word == NV_W'(tap_pos)));
endmodule

bind updown_wiper_ctrl wiper_ctrl_chk #(
    .TAP_W(TAP_W),
    .NV_W (NV_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tap_pos(tap_pos),
    .nv_word(nv_word),
    .busy   (busy)
);

// File: tb/sim_updown_wiper_ctrl.sv
// Bench: sweeps the wiper over its full range in both directions and
// exercises save, discard, busy-window traffic and power-on recall.
module sim_updown_wiper_ctrl;
    localparam int unsigned TAP_W   = 7;
    localparam int unsigned NV_W    = 8;
    localparam int unsigned WR_CYC  = 400;
    localparam int unsigned RC_CYC  = 4;
    localparam int          TOP     = (1 << TAP_W) - 1;
    localparam logic [NV_W-1:0] INIT_WORD = 8'h25;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sel_n, step_n, dir_up;
    logic [TAP_W-1:0] tap_pos;
    logic [NV_W-1:0]  nv_word;
    logic             busy;

    int n_cmp  = 0;
    int n_bad  = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    updown_wiper_ctrl #(
        .TAP_W        (TAP_W),
        .NV_W         (NV_W),
        .SYNC_STAGES  (2),
        .WRITE_CYCLES (WR_CYC),
        .RECALL_CYCLES(RC_CYC),
        .NV_INIT      (INIT_WORD)
    ) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (sel_n),
        .step_n (step_n),
        .dir_up (dir_up),
        .tap_pos(tap_pos),
        .nv_word(nv_word),
        .busy   (busy)
    );

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        @(negedge clk);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one full strobe with the given direction
    task automatic strobe(input bit up);
        dir_up = up;
        cycles(8);
        step_n = 1'b0;
        cycles(30);
        step_n = 1'b1;
        cycles(30);
    endtask

    task automatic power_on();
        sel_n = 1'b1; step_n = 1'b1; dir_up = 1'b0;
        rst_n = 1'b0;
        cycles(5);
        check("R1 busy in reset", busy, 1);
        rst_n = 1'b1;
        cycles(2);
        check("R1 busy during recall", busy, 1);
        cycles(20);
        check("R1 busy after recall", busy, 0);
    endtask

    initial begin
        power_on();
        model = INIT_WORD;
        check("R1 recalled position", tap_pos, model);
        check("R1 saved word", nv_word, INIT_WORD);

        // R6: deselected strobes in both directions do nothing
        for (int i = 0; i < 4; i++) strobe(i[0]);
        check("R6 standby position", tap_pos, model);

        // R2 / R4: up sweep past the top
        sel_n = 1'b0;
        cycles(20);
        for (int i = model; i < TOP + 3; i++) begin
            strobe(1'b1);
            model = (model < TOP) ? model + 1 : TOP;
            check((model == TOP) ? "R4 top stop" : "R2 up step", tap_pos, model);
        end

        // R3 / R5: down sweep past the bottom
        for (int i = 0; i < TOP + 3; i++) begin
            strobe(1'b0);
            model = (model > 0) ? model - 1 : 0;
            check((model == 0) ? "R5 bottom stop" : "R3 down step", tap_pos, model);
        end

        // R7: save position 9
        for (int i = 0; i < 9; i++) strobe(1'b1);
        model = 9;
        check("R2 climb to 9", tap_pos, model);
        sel_n = 1'b1;
        cycles(10);
        check("R7 busy in write", busy, 1);

        // R9: traffic inside the write window
        sel_n = 1'b0;
        cycles(10);
        strobe(1'b1);
        strobe(1'b1);
        check("R9 frozen position", tap_pos, model);
        sel_n = 1'b1;
        cycles(10);
        check("R9 still busy", busy, 1);
        cycles(WR_CYC + 30);
        check("R7 write done", busy, 0);
        check("R7 saved value", nv_word, 9);
        check("R10 position kept", tap_pos, 9);

        // R8: deselect with strobe low discards
        sel_n = 1'b0;
        cycles(20);
        for (int i = 0; i < 3; i++) strobe(1'b1);
        dir_up = 1'b1;
        cycles(8);
        step_n = 1'b0;
        cycles(30);
        model = 13;
        sel_n = 1'b1;
        cycles(10);
        check("R8 no busy", busy, 0);
        step_n = 1'b1;
        cycles(WR_CYC + 30);
        check("R8 word unchanged", nv_word, 9);
        check("R8 position", tap_pos, model);

        // R10: power cycle recalls the saved position
        power_on();
        check("R10 recall after save", tap_pos, 9);
        check("R10 saved word", nv_word, 9);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        cycles(200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule